// File: doc/BRIEF.md
# Serial Command Receiver for a Dot-Matrix Display Controller

This block sits at the host-facing edge of a dot-matrix display controller. The host drives three wires: an active-low select, a shift clock and a data line. The block brings these into the system clock domain and gathers the bits into 8-bit words. It then treats each word as a command or as a data byte for a RAM stream that is already open.

Single-byte commands load registers that stay on the outputs: a 4-bit general output port, a 3-bit brightness duty code, a 4-bit digit-count code and two all-lights flags. Three stream commands each set a start address. The bytes that follow then become write strobes on one of three RAM ports: a 32-entry character-code RAM, a 32-entry 4-bit symbol RAM, and a 16-entry pattern RAM whose 35-bit words are built from five column bytes. Addresses advance by themselves after every store. The RAM arrays, the character ROM and display scanning sit outside this block.

Top module: `vfd_cmd_rx`

## Requirements
- R1: A bit is taken on each rising edge of `sck_i` while `csn_i` is low. Bits arrive least significant first, and every 8 bits counted from the fall of `csn_i` form one word. Clock edges while `csn_i` is high are ignored, and a rise of `csn_i` throws away a partly received word.
- R2: Bits 7..5 of a command byte select the operation: 001 character-code stream, 010 pattern stream, 011 symbol stream, 100 port set, 101 duty set, 110 digit-count set, 111 all-lights set.
- R3: Port set loads `port_o` from bits 3..0. Duty set loads `duty_o` from bits 2..0. Digit-count set loads `digits_o` from bits 3..0. All-lights set loads `lamp_low_o` from bit 0 and `lamp_high_o` from bit 1. These outputs change only when such a command arrives.
- R4: In a character-code stream the start address is bits 4..0 of the command byte. Each data byte is stored whole, with a one-cycle `code_we_o`. The 5-bit address then steps by one and wraps from 1Fh to 00h.
- R5: In a symbol stream the start address is bits 4..0 of the command byte. Only bits 3..0 of each data byte are stored, and addressing follows the same rule as R4.
- R6: A data byte aimed at character-code or symbol address 18h..1Fh gives no strobe, but the address still advances.
- R7: In a pattern stream the start address is bits 3..0 of the command byte. Data byte k (k = 0..4) gives its bits 6..0 to pattern bits k, k+5, ..., k+30, and its bit 7 is ignored. After the fifth byte, one `pat_we_o` writes the 35-bit word, and the 4-bit address steps by one and wraps from 0Fh to 00h.
- R8: After a stream command, every later word is data for that RAM until `csn_i` rises, whatever its top bits. The first word after the next fall of `csn_i` is decoded as a command.
- R9: A rise of `csn_i` in the middle of a pattern character drops the columns gathered so far. The next pattern stream starts again at column 0.
- R10: A command byte with bits 7..5 = 000 changes no output and no internal state.
- R11: Reset clears `port_o`, `duty_o`, `digits_o` and all RAM addresses to 0, sets `lamp_low_o` to 1 and `lamp_high_o` to 0, and gives no write strobe.
- R12: No more than one RAM write strobe is high in any cycle, and a strobe is raised only in the cycle after a word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Serial select, active low (asynchronous) |
| sck_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data (asynchronous) |
| port_o | output | 4 | General output port value |
| duty_o | output | 3 | Brightness duty code |
| digits_o | output | 4 | Digit-count code |
| lamp_low_o | output | 1 | All-lights flag L (force outputs low) |
| lamp_high_o | output | 1 | All-lights flag H (force outputs high) |
| code_we_o | output | 1 | Character-code RAM write strobe |
| code_addr_o | output | 5 | Character-code RAM write address |
| code_data_o | output | 8 | Character-code RAM write data |
| sym_we_o | output | 1 | Symbol RAM write strobe |
| sym_addr_o | output | 5 | Symbol RAM write address |
| sym_data_o | output | 4 | Symbol RAM write data |
| pat_we_o | output | 1 | Pattern RAM write strobe |
| pat_addr_o | output | 4 | Pattern RAM write address |
| pat_data_o | output | 35 | Pattern RAM write data |

## Verification
The decoder is driven with runs of random register-command bytes, packed several to one select window. These runs show whether the opcode and field bits are routed to the right register. Character-code and symbol streams start near the top of the used range, so the drop window at 18h..1Fh and the wrap back to 00h both appear in one burst. Random upper nibbles in the symbol stream show whether those bits are masked. Pattern streams starting at 0Fh check the column interleave and the 4-bit wrap. Directed cases then separate the select-window rules: a data byte that looks like a command inside a stream, a select rise in the middle of a pattern or a byte, clocks while deselected, and the reserved opcode.

// File: rtl/vfd_rx_pkg.sv
package vfd_rx_pkg;
  typedef enum logic [2:0] {
    OP_TEST   = 3'b000,
    OP_CODE   = 3'b001,
    OP_PAT    = 3'b010,
    OP_SYM    = 3'b011,
    OP_PORT   = 3'b100,
    OP_DUTY   = 3'b101,
    OP_DIGITS = 3'b110,
    OP_LAMP   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_CODE,
    ST_PAT,
    ST_SYM
  } mode_e;
endpackage

// File: rtl/vfd_rx_front.sv
module vfd_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sck_rise_o,
  output logic sdi_o,
  output logic cs_idle_o,
  output logic cs_rise_o
);
  logic [SYNC_STAGES-1:0] csn_ff, sck_ff, sdi_ff;
  logic csn_d, sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_ff <= '1;
      sck_ff <= '0;
      sdi_ff <= '0;
      csn_d  <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      csn_ff <= {csn_ff[SYNC_STAGES-2:0], csn_i};
      sck_ff <= {sck_ff[SYNC_STAGES-2:0], sck_i};
      sdi_ff <= {sdi_ff[SYNC_STAGES-2:0], sdi_i};
      csn_d  <= csn_ff[SYNC_STAGES-1];
      sck_d  <= sck_ff[SYNC_STAGES-1];
    end
  end

  assign cs_idle_o  = csn_ff[SYNC_STAGES-1];
  assign cs_rise_o  = csn_ff[SYNC_STAGES-1] & ~csn_d;
  assign sck_rise_o = sck_ff[SYNC_STAGES-1] & ~sck_d & ~csn_ff[SYNC_STAGES-1];
  assign sdi_o      = sdi_ff[SYNC_STAGES-1];
endmodule

// File: rtl/vfd_rx_shift.sv
module vfd_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sck_rise_i,
  input  logic         sdi_i,
  input  logic         cs_idle_i,
  output logic         byte_vld_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sr_next;

  assign sr_next = {sdi_i, sr[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr         <= '0;
      cnt        <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (cs_idle_i) begin
        cnt <= '0;
      end else if (sck_rise_i) begin
        sr <= sr_next;
        if (cnt == LAST) begin
          cnt        <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= sr_next;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vfd_rx_decode.sv
module vfd_rx_decode
  import vfd_rx_pkg::*;
#(
  parameter int CODE_AW   = 5,
  parameter int CODE_USED = 24,
  parameter int CODE_DW   = 8,
  parameter int SYM_DW    = 4,
  parameter int PAT_AW    = 4,
  parameter int PAT_COLS  = 5,
  parameter int PAT_ROWS  = 7,
  parameter int PORT_W    = 4,
  parameter int DUTY_W    = 3,
  parameter int DIG_W     = 4,
  localparam int PAT_W    = PAT_COLS * PAT_ROWS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               cs_idle_i,
  output logic [PORT_W-1:0]  port_o,
  output logic [DUTY_W-1:0]  duty_o,
  output logic [DIG_W-1:0]   digits_o,
  output logic               lamp_low_o,
  output logic               lamp_high_o,
  output logic               code_we_o,
  output logic [CODE_AW-1:0] code_addr_o,
  output logic [CODE_DW-1:0] code_data_o,
  output logic               sym_we_o,
  output logic [CODE_AW-1:0] sym_addr_o,
  output logic [SYM_DW-1:0]  sym_data_o,
  output logic               pat_we_o,
  output logic [PAT_AW-1:0]  pat_addr_o,
  output logic [PAT_W-1:0]   pat_data_o
);
  localparam int COL_W = $clog2(PAT_COLS);
  localparam logic [CODE_AW-1:0] CODE_LAST = CODE_AW'(CODE_USED - 1);
  localparam logic [COL_W-1:0]   COL_LAST  = COL_W'(PAT_COLS - 1);

  mode_e              mode;
  logic [CODE_AW-1:0] code_ptr, sym_ptr;
  logic [PAT_AW-1:0]  pat_ptr;
  logic [COL_W-1:0]   col;
  logic [PAT_W-1:0]   acc, pat_next;

  // drop this column's rows into the interleaved word
  always_comb begin
    pat_next = acc;
    for (int c = 0; c < PAT_COLS; c++) begin
      for (int r = 0; r < PAT_ROWS; r++) begin
        if (col == COL_W'(c)) pat_next[c + PAT_COLS*r] = byte_i[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode        <= ST_CMD;
      code_ptr    <= '0;
      sym_ptr     <= '0;
      pat_ptr     <= '0;
      col         <= '0;
      acc         <= '0;
      port_o      <= '0;
      duty_o      <= '0;
      digits_o    <= '0;
      lamp_low_o  <= 1'b1;
      lamp_high_o <= 1'b0;
      code_we_o   <= 1'b0;
      code_addr_o <= '0;
      code_data_o <= '0;
      sym_we_o    <= 1'b0;
      sym_addr_o  <= '0;
      sym_data_o  <= '0;
      pat_we_o    <= 1'b0;
      pat_addr_o  <= '0;
      pat_data_o  <= '0;
    end else begin
      code_we_o <= 1'b0;
      sym_we_o  <= 1'b0;
      pat_we_o  <= 1'b0;
      if (cs_idle_i) begin
        mode <= ST_CMD;
        col  <= '0;
        acc  <= '0;
      end else if (byte_vld_i) begin
        case (mode)
          ST_CMD: begin
            case (op_e'(byte_i[7:5]))
              OP_CODE: begin
                mode     <= ST_CODE;
                code_ptr <= byte_i[CODE_AW-1:0];
              end
              OP_SYM: begin
                mode    <= ST_SYM;
                sym_ptr <= byte_i[CODE_AW-1:0];
              end
              OP_PAT: begin
                mode    <= ST_PAT;
                pat_ptr <= byte_i[PAT_AW-1:0];
                col     <= '0;
                acc     <= '0;
              end
              OP_PORT:   port_o   <= byte_i[PORT_W-1:0];
              OP_DUTY:   duty_o   <= byte_i[DUTY_W-1:0];
              OP_DIGITS: digits_o <= byte_i[DIG_W-1:0];
              OP_LAMP: begin
                lamp_low_o  <= byte_i[0];
                lamp_high_o <= byte_i[1];
              end
              default: ;
            endcase
          end
          ST_CODE: begin
            if (code_ptr <= CODE_LAST) begin
              code_we_o   <= 1'b1;
              code_addr_o <= code_ptr;
              code_data_o <= byte_i[CODE_DW-1:0];
            end
            code_ptr <= code_ptr + 1'b1;
          end
          ST_SYM: begin
            if (sym_ptr <= CODE_LAST) begin
              sym_we_o   <= 1'b1;
              sym_addr_o <= sym_ptr;
              sym_data_o <= byte_i[SYM_DW-1:0];
            end
            sym_ptr <= sym_ptr + 1'b1;
          end
          ST_PAT: begin
            if (col == COL_LAST) begin
              pat_we_o   <= 1'b1;
              pat_addr_o <= pat_ptr;
              pat_data_o <= pat_next;
              pat_ptr    <= pat_ptr + 1'b1;
              col        <= '0;
              acc        <= '0;
            end else begin
              acc <= pat_next;
              col <= col + 1'b1;
            end
          end
          default: mode <= ST_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CODE_AW     = 5,
  parameter int CODE_USED   = 24,
  parameter int CODE_DW     = 8,
  parameter int SYM_DW      = 4,
  parameter int PAT_AW      = 4,
  parameter int PAT_COLS    = 5,
  parameter int PAT_ROWS    = 7,
  parameter int PORT_W      = 4,
  parameter int DUTY_W      = 3,
  parameter int DIG_W       = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         csn_i,
  input  logic                         sck_i,
  input  logic                         sdi_i,
  output logic [PORT_W-1:0]            port_o,
  output logic [DUTY_W-1:0]            duty_o,
  output logic [DIG_W-1:0]             digits_o,
  output logic                         lamp_low_o,
  output logic                         lamp_high_o,
  output logic                         code_we_o,
  output logic [CODE_AW-1:0]           code_addr_o,
  output logic [CODE_DW-1:0]           code_data_o,
  output logic                         sym_we_o,
  output logic [CODE_AW-1:0]           sym_addr_o,
  output logic [SYM_DW-1:0]            sym_data_o,
  output logic                         pat_we_o,
  output logic [PAT_AW-1:0]            pat_addr_o,
  output logic [PAT_COLS*PAT_ROWS-1:0] pat_data_o
);
  logic       sck_rise, sdi_s, cs_idle, cs_rise;
  logic       byte_vld;
  logic [7:0] byte_q;

  vfd_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_i      (csn_i),
    .sck_i      (sck_i),
    .sdi_i      (sdi_i),
    .sck_rise_o (sck_rise),
    .sdi_o      (sdi_s),
    .cs_idle_o  (cs_idle),
    .cs_rise_o  (cs_rise)
  );

  vfd_rx_shift #(.W(8)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (sck_rise),
    .sdi_i      (sdi_s),
    .cs_idle_i  (cs_idle | cs_rise),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_q)
  );

  vfd_rx_decode #(
    .CODE_AW(CODE_AW), .CODE_USED(CODE_USED), .CODE_DW(CODE_DW), .SYM_DW(SYM_DW),
    .PAT_AW(PAT_AW), .PAT_COLS(PAT_COLS), .PAT_ROWS(PAT_ROWS),
    .PORT_W(PORT_W), .DUTY_W(DUTY_W), .DIG_W(DIG_W)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_q),
    .cs_idle_i   (cs_idle),
    .port_o      (port_o),
    .duty_o      (duty_o),
    .digits_o    (digits_o),
    .lamp_low_o  (lamp_low_o),
    .lamp_high_o (lamp_high_o),
    .code_we_o   (code_we_o),
    .code_addr_o (code_addr_o),
    .code_data_o (code_data_o),
    .sym_we_o    (sym_we_o),
    .sym_addr_o  (sym_addr_o),
    .sym_data_o  (sym_data_o),
    .pat_we_o    (pat_we_o),
    .pat_addr_o  (pat_addr_o),
    .pat_data_o  (pat_data_o)
  );
endmodule

// File: rtl/vfd_cmd_rx_chk.sv
module vfd_cmd_rx_chk #(
  parameter int CODE_AW   = 5,
  parameter int CODE_USED = 24,
  parameter int PORT_W    = 4,
  parameter int DUTY_W    = 3,
  parameter int DIG_W     = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               byte_vld_i,
  input logic               code_we_i,
  input logic [CODE_AW-1:0] code_addr_i,
  input logic               sym_we_i,
  input logic [CODE_AW-1:0] sym_addr_i,
  input logic               pat_we_i,
  input logic [PORT_W-1:0]  port_i,
  input logic [DUTY_W-1:0]  duty_i,
  input logic [DIG_W-1:0]   digits_i
);
  localparam logic [CODE_AW-1:0] LAST = CODE_AW'(CODE_USED - 1);

  p_one_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({code_we_i, sym_we_i, pat_we_i}));

  p_strobe_after_word_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_we_i | sym_we_i | pat_we_i) |-> $past(byte_vld_i));

  p_code_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_we_i |-> (code_addr_i <= LAST));

  p_sym_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_we_i |-> (sym_addr_i <= LAST));

  p_regs_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_vld_i) |-> $stable({port_i, duty_i, digits_i}));
endmodule

bind vfd_cmd_rx vfd_cmd_rx_chk #(
  .CODE_AW(CODE_AW), .CODE_USED(CODE_USED),
  .PORT_W(PORT_W), .DUTY_W(DUTY_W), .DIG_W(DIG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_vld_i  (byte_vld),
  .code_we_i   (code_we_o),
  .code_addr_i (code_addr_o),
  .sym_we_i    (sym_we_o),
  .sym_addr_i  (sym_addr_o),
  .pat_we_i    (pat_we_o),
  .port_i      (port_o),
  .duty_i      (duty_o),
  .digits_i    (digits_o)
);

// File: tb/vfd_cmd_rx_test.sv
module vfd_cmd_rx_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;

  logic [3:0]  port_o;
  logic [2:0]  duty_o;
  logic [3:0]  digits_o;
  logic        lamp_low_o, lamp_high_o;
  logic        code_we_o, sym_we_o, pat_we_o;
  logic [4:0]  code_addr_o, sym_addr_o;
  logic [7:0]  code_data_o;
  logic [3:0]  sym_data_o, pat_addr_o;
  logic [34:0] pat_data_o;

  always #2.5 clk = ~clk;

  vfd_cmd_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .port_o(port_o), .duty_o(duty_o), .digits_o(digits_o),
    .lamp_low_o(lamp_low_o), .lamp_high_o(lamp_high_o),
    .code_we_o(code_we_o), .code_addr_o(code_addr_o), .code_data_o(code_data_o),
    .sym_we_o(sym_we_o), .sym_addr_o(sym_addr_o), .sym_data_o(sym_data_o),
    .pat_we_o(pat_we_o), .pat_addr_o(pat_addr_o), .pat_data_o(pat_data_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // observed writes
  logic [7:0]  obs_code [32];
  logic [3:0]  obs_sym  [32];
  logic [34:0] obs_pat  [16];
  int obs_code_n = 0, obs_sym_n = 0, obs_pat_n = 0;

  // expected model (built from the requirement text)
  logic [7:0]  exp_code [32];
  logic [3:0]  exp_sym  [32];
  logic [34:0] exp_pat  [16];
  int exp_code_n = 0, exp_sym_n = 0, exp_pat_n = 0;
  logic [3:0] e_port = 4'h0, e_digits = 4'h0;
  logic [2:0] e_duty = 3'h0;
  logic e_low = 1'b1, e_high = 1'b0;
  int m_mode = 0; // 0 command, 1 code, 2 pattern, 3 symbol
  logic [4:0] m_code = 5'h0, m_sym = 5'h0;
  logic [3:0] m_pat = 4'h0;
  int m_col = 0;
  logic [34:0] m_acc = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (code_we_o) begin obs_code[code_addr_o] = code_data_o; obs_code_n++; end
      if (sym_we_o)  begin obs_sym[sym_addr_o]   = sym_data_o;  obs_sym_n++;  end
      if (pat_we_o)  begin obs_pat[pat_addr_o]   = pat_data_o;  obs_pat_n++;  end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_mode)
      0: case (b[7:5])
        3'b001: begin m_mode = 1; m_code = b[4:0]; end
        3'b010: begin m_mode = 2; m_pat = b[3:0]; m_col = 0; m_acc = '0; end
        3'b011: begin m_mode = 3; m_sym = b[4:0]; end
        3'b100: e_port = b[3:0];
        3'b101: e_duty = b[2:0];
        3'b110: e_digits = b[3:0];
        3'b111: begin e_low = b[0]; e_high = b[1]; end
        default: ;
      endcase
      1: begin
        if (m_code < 5'd24) begin exp_code[m_code] = b; exp_code_n++; end
        m_code = m_code + 5'd1;
      end
      3: begin
        if (m_sym < 5'd24) begin exp_sym[m_sym] = b[3:0]; exp_sym_n++; end
        m_sym = m_sym + 5'd1;
      end
      default: begin
        for (int r = 0; r < 7; r++) m_acc[m_col + 5*r] = b[r];
        if (m_col == 4) begin
          exp_pat[m_pat] = m_acc; exp_pat_n++;
          m_pat = m_pat + 4'd1; m_col = 0; m_acc = '0;
        end else m_col++;
      end
    endcase
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 1'b0; sdi = b[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    repeat (6) @(negedge clk);
    model_byte(b);
  endtask

  task automatic cs_low();
    @(negedge clk); sck = 1'b0; csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); sck = 1'b0; csn = 1'b1;
    repeat (6) @(negedge clk);
    m_mode = 0; m_col = 0; m_acc = '0;
  endtask

  task automatic check_regs(input string req);
    check(req, {60'd0, port_o}, {60'd0, e_port});
    check(req, {61'd0, duty_o}, {61'd0, e_duty});
    check(req, {60'd0, digits_o}, {60'd0, e_digits});
    check(req, {62'd0, lamp_high_o, lamp_low_o}, {62'd0, e_high, e_low});
  endtask

  task automatic check_rams(input string req);
    check(req, 64'(obs_code_n), 64'(exp_code_n));
    check(req, 64'(obs_sym_n), 64'(exp_sym_n));
    check(req, 64'(obs_pat_n), 64'(exp_pat_n));
    for (int a = 0; a < 32; a++) begin
      if (obs_code[a] !== exp_code[a]) check(req, 64'(obs_code[a]), 64'(exp_code[a]));
      if (obs_sym[a] !== exp_sym[a])   check(req, 64'(obs_sym[a]), 64'(exp_sym[a]));
    end
    for (int a = 0; a < 16; a++)
      if (obs_pat[a] !== exp_pat[a]) check(req, 64'(obs_pat[a]), 64'(exp_pat[a]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd5150));
    for (int a = 0; a < 32; a++) begin
      obs_code[a] = 8'h00; exp_code[a] = 8'h00; obs_sym[a] = 4'h0; exp_sym[a] = 4'h0;
    end
    for (int a = 0; a < 16; a++) begin obs_pat[a] = '0; exp_pat[a] = '0; end
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check_regs("R11");
    check("R11", 64'(obs_code_n + obs_sym_n + obs_pat_n), 64'd0);

    // R2 R3 random register commands, several per window
    for (int k = 0; k < 12; k++) begin
      cs_low();
      for (int j = 0; j < 3; j++) begin
        b = 8'($urandom);
        b[7] = 1'b1;
        send_byte(b);
      end
      cs_high();
      check_regs("R2_R3");
    end

    // R10 reserved opcode
    cs_low(); send_byte(8'h1D); send_byte(8'h0F); cs_high();
    check_regs("R10");
    check_rams("R10");

    // R4 R6 character stream from 15h across drop window and wrap
    cs_low(); send_byte(8'h35);
    for (int j = 0; j < 12; j++) send_byte(8'($urandom));
    cs_high();
    check("R6", 64'(obs_code_n), 64'd4);
    check_rams("R4_R6");

    // R5 symbol stream with random upper nibble
    cs_low(); send_byte(8'h76);
    for (int j = 0; j < 11; j++) send_byte(8'($urandom));
    cs_high();
    check("R5", 64'(obs_sym_n), 64'd3);
    check_rams("R5");

    // R7 pattern stream from 0Fh, wraps to 00h
    cs_low(); send_byte(8'h4F);
    for (int j = 0; j < 10; j++) send_byte(8'($urandom));
    cs_high();
    check("R7", 64'(obs_pat_n), 64'd2);
    check_rams("R7");

    // R8 command-like data inside a stream
    cs_low(); send_byte(8'h23); send_byte(8'h9F); send_byte(8'hB7); cs_high();
    check_regs("R8");
    check_rams("R8");
    cs_low(); send_byte(8'h8A); cs_high();
    check("R8", 64'(port_o), 64'hA);

    // R9 select rise in the middle of a pattern character
    cs_low(); send_byte(8'h45);
    for (int j = 0; j < 3; j++) send_byte(8'($urandom));
    cs_high();
    check("R9", 64'(obs_pat_n), 64'(exp_pat_n));
    cs_low(); send_byte(8'h45);
    for (int j = 0; j < 5; j++) send_byte(8'($urandom));
    cs_high();
    check_rams("R9");

    // R1 partial word dropped, clocks while deselected ignored
    cs_low(); send_bits(8'hFF, 5); cs_high();
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); sdi = 1'($urandom); sck = ~sck;
      repeat (3) @(negedge clk);
    end
    sck = 1'b0;
    check_regs("R1");
    cs_low(); send_byte(8'hA6); send_byte(8'h83); cs_high();
    check_regs("R1");
    check("R1", 64'(duty_o), 64'h6);

    // mixed random traffic
    for (int k = 0; k < 10; k++) begin
      cs_low();
      case ($urandom_range(0, 3))
        0: begin send_byte({3'b001, 5'($urandom)}); for (int j = 0; j < 6; j++) send_byte(8'($urandom)); end
        1: begin send_byte({3'b011, 5'($urandom)}); for (int j = 0; j < 6; j++) send_byte(8'($urandom)); end
        2: begin send_byte({4'b0100, 4'($urandom)}); for (int j = 0; j < 7; j++) send_byte(8'($urandom)); end
        default: begin send_byte({1'b1, 7'($urandom)}); send_byte({1'b1, 7'($urandom)}); end
      endcase
      cs_high();
      check_regs("R2_R3");
    end
    check_rams("R4_R5_R7");

    finish_run();
  end
endmodule